// File: doc/BRIEF.md
# Parallel Host Bus Byte-Order Adapter

This block sits between a host processor's 8-bit parallel bus and an internal byte-addressed space that holds registers and RAM. The host reaches the space with an 11-bit address, an active-low chip select and active-low read and write strobes. Internally every 16-bit quantity keeps its low byte at the even address. A 16-bit value is always moved as two byte accesses at adjacent addresses.

A mode input states the host's byte order. With a little-endian host every address goes straight through. With a big-endian host, four 16-bit locations are reached with their byte lanes exchanged, so the host sees the numeric value in its own order. These are the interrupt word, the status word, the first mode word and the user watchdog reload cell. Every other location is untouched.

Reads are combinational toward a memory with an asynchronous read port. Writes are captured while the strobe is low and are committed to the memory-side write port one clock after the strobe's rising edge is seen.

Top module: `pbo_bus_adapter`

## Requirements
- R1: While `rst_n` is low, `mem_we` and `host_doe` are both 0 when `host_cs_n` is high.
- R2: With `big_endian` = 0, the memory-side read address equals `host_addr`, and a committed write goes to `host_addr`, for every address.
- R3: With `big_endian` = 1, any address whose bits [10:1] match a swapped word is sent to memory with bit 0 inverted, for both reads and writes. The swapped words have even bases 0x010 (interrupt), 0x012 (status), 0x014 (mode word 0) and 0x07C (watchdog reload cell). As a result, the host's even address reaches the high byte.
- R4: With `big_endian` = 1, addresses outside the four swapped words, including their immediate neighbours, are sent to memory unchanged.
- R5: Each rising edge of `host_wr_n` is sampled at a clock edge where the previous sample was low and `host_cs_n` is low. Each such edge produces exactly one cycle of `mem_we`, starting after that clock edge. `mem_waddr` and `mem_wdata` carry the translated address and the data last captured while `host_wr_n` and `host_cs_n` were both low.
- R6: A write strobe pulse given while `host_cs_n` is high produces no `mem_we`, and memory content is unchanged.
- R7: `host_doe` is 1 exactly when `host_cs_n` and `host_rd_n` are both low. While it is 1, `host_dout` equals `mem_rdata` for the translated read address.
- R8: A write commit and a host read of the same byte may fall in the same cycle. The read returns the old byte in the commit cycle and the new byte in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Host byte order: 0 little-endian, 1 big-endian |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 11 | Host byte address |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Read data toward the host |
| host_doe | output | 1 | Enable for driving `host_dout` onto the host bus |
| mem_raddr | output | 11 | Translated memory read address |
| mem_rdata | input | 8 | Memory read data (asynchronous read) |
| mem_waddr | output | 11 | Translated memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable, one cycle per host write |

## Verification
A write commit and a host read of the same swapped byte can share a cycle. To provoke this, the bench raises the write strobe and lowers the read strobe at the same negative edge, with the address held on a swapped word in big-endian mode. It then judges the read data against the bench's own memory model: the old byte is expected in the commit cycle and the new byte in the following cycle. The per-cycle model also compares the commit pulse, its translated address and its data against its own behavioural account of the strobes.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
    localparam int ADDR_W   = 11;
    localparam int DATA_W   = 8;
    localparam int NUM_SWAP = 4;

    // Even base addresses of the 16-bit words whose lanes are exchanged
    // for a big-endian host: interrupt, status, mode word 0, watchdog reload.
    localparam logic [ADDR_W-1:0] SWAP_BASE [NUM_SWAP] =
        '{11'h010, 11'h012, 11'h014, 11'h07C};

    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } byte_order_e;
endpackage

// File: rtl/pbo_swap_match.sv
module pbo_swap_match
    import pbo_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int NSWAP = NUM_SWAP
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic [NSWAP-1:0] hits;

    for (genvar i = 0; i < NSWAP; i++) begin : g_cmp
        localparam logic [AW-1:0] BASE = AW'(SWAP_BASE[i]);
        assign hits[i] = (addr[AW-1:1] == BASE[AW-1:1]);
    end

    assign hit = |hits;
endmodule

// File: rtl/pbo_addr_xlate.sv
module pbo_addr_xlate
    import pbo_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          big_endian,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);
    logic in_list;

    pbo_swap_match #(.AW(AW), .NSWAP(NUM_SWAP)) u_match (
        .addr (addr_in),
        .hit  (in_list)
    );

    always_comb begin
        addr_out = addr_in;
        if ((byte_order_e'(big_endian) == ORDER_BIG) && in_list) begin
            addr_out[0] = ~addr_in[0];
        end
    end
endmodule

// File: rtl/pbo_write_ctl.sv
module pbo_write_ctl
    import pbo_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          big_endian,
    input  logic          host_cs_n,
    input  logic          host_wr_n,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_din,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata
);
    typedef struct packed {
        logic          wr_n_prev;
        logic [AW-1:0] lat_addr;
        logic [DW-1:0] lat_data;
        logic          commit;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
    } wstate_t;

    wstate_t       st_d, st_q;
    logic [AW-1:0] lat_xaddr;

    pbo_addr_xlate #(.AW(AW)) u_wr_xlate (
        .big_endian (big_endian),
        .addr_in    (st_q.lat_addr),
        .addr_out   (lat_xaddr)
    );

    always_comb begin
        st_d        = st_q;
        st_d.commit = !st_q.wr_n_prev && host_wr_n && !host_cs_n;
        if (st_d.commit) begin
            st_d.waddr = lat_xaddr;
            st_d.wdata = st_q.lat_data;
        end
        if (!host_wr_n && !host_cs_n) begin
            st_d.lat_addr = host_addr;
            st_d.lat_data = host_din;
        end
        st_d.wr_n_prev = host_wr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.wr_n_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = st_q.commit;
    assign mem_waddr = st_q.waddr;
    assign mem_wdata = st_q.wdata;
endmodule

// File: rtl/pbo_bus_adapter.sv
module pbo_bus_adapter
    import pbo_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          big_endian,
    input  logic          host_cs_n,
    input  logic          host_rd_n,
    input  logic          host_wr_n,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] host_dout,
    output logic          host_doe,
    output logic [AW-1:0] mem_raddr,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we
);
    pbo_addr_xlate #(.AW(AW)) u_rd_xlate (
        .big_endian (big_endian),
        .addr_in    (host_addr),
        .addr_out   (mem_raddr)
    );

    pbo_write_ctl #(.AW(AW), .DW(DW)) u_wr_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .big_endian (big_endian),
        .host_cs_n  (host_cs_n),
        .host_wr_n  (host_wr_n),
        .host_addr  (host_addr),
        .host_din   (host_din),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata)
    );

    always_comb begin
        host_doe  = !host_cs_n && !host_rd_n;
        host_dout = host_doe ? mem_rdata : '0;
    end
endmodule

// File: rtl/pbo_bus_adapter_chk.sv
module pbo_bus_adapter_chk
    import pbo_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          big_endian,
    input logic          host_cs_n,
    input logic          host_rd_n,
    input logic          host_wr_n,
    input logic [AW-1:0] host_addr,
    input logic [DW-1:0] host_din,
    input logic [DW-1:0] host_dout,
    input logic          host_doe,
    input logic [AW-1:0] mem_raddr,
    input logic [DW-1:0] mem_rdata,
    input logic [AW-1:0] mem_waddr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_we
);
    function automatic logic listed(input logic [AW-1:0] a);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_SWAP; i++) begin
            if ((a >> 1) == (AW'(SWAP_BASE[i]) >> 1)) r = 1'b1;
        end
        return r;
    endfunction

    // R2
    le_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !big_endian |-> mem_raddr == host_addr);

    // R3
    be_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (big_endian && listed(host_addr)) |-> mem_raddr == (host_addr ^ AW'(1)));

    // R4
    be_unlisted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (big_endian && !listed(host_addr)) |-> mem_raddr == host_addr);

    // R5
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R5
    we_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(host_wr_n) && $past(!host_cs_n));

    // R6
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs_n && !mem_we) |=> !mem_we);

    // R7
    doe_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_n |-> !host_doe);
endmodule

bind pbo_bus_adapter pbo_bus_adapter_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/pbo_bus_adapter_bench.sv
`timescale 1ns/1ps
module pbo_bus_adapter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic        host_cs_n = 1'b1;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic [10:0] host_addr = '0;
    logic [7:0]  host_din = '0;
    logic [7:0]  host_dout;
    logic        host_doe;
    logic [10:0] mem_raddr;
    logic [7:0]  mem_rdata;
    logic [10:0] mem_waddr;
    logic [7:0]  mem_wdata;
    logic        mem_we;

    int tests = 0;
    int fails = 0;

    logic [7:0] bmem [2048];

    always #4 clk = ~clk;

    pbo_bus_adapter u_pbo_bus_adapter (
        .clk, .rst_n, .big_endian, .host_cs_n, .host_rd_n, .host_wr_n,
        .host_addr, .host_din, .host_dout, .host_doe, .mem_raddr,
        .mem_rdata, .mem_waddr, .mem_wdata, .mem_we
    );

    assign mem_rdata = bmem[mem_raddr];

    function automatic bit is_swapped(input logic [10:0] a);
        int w;
        w = int'(a) / 2;
        return (w == 8) || (w == 9) || (w == 10) || (w == 62);
    endfunction

    function automatic logic [10:0] ref_map(input logic [10:0] a, input logic be);
        if (be && is_swapped(a)) return (a % 2 == 0) ? a + 11'd1 : a - 11'd1;
        return a;
    endfunction

    function automatic string req_of(input logic [10:0] a, input logic be);
        if (!be) return "R2";
        return is_swapped(a) ? "R3" : "R4";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference for the write commit
    bit          m_prev_low = 1'b0;
    bit          m_have = 1'b0;
    logic [10:0] m_addr = '0;
    logic [7:0]  m_data = '0;
    bit          e_we = 1'b0;
    logic [10:0] e_waddr = '0;
    logic [7:0]  e_wdata = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prev_low = 1'b0;
            e_we = 1'b0;
        end else begin
            if (mem_we) bmem[mem_waddr] = mem_wdata;
            e_we = m_prev_low && host_wr_n && !host_cs_n;
            if (e_we) begin
                e_waddr = ref_map(m_addr, big_endian);
                e_wdata = m_data;
            end
            if (!host_wr_n && !host_cs_n) begin
                m_addr = host_addr;
                m_data = host_din;
                m_have = 1'b1;
            end
            m_prev_low = !host_wr_n;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check("R5 we", int'(mem_we), int'(e_we));
            if (e_we) begin
                check("R5 waddr", int'(mem_waddr), int'(e_waddr));
                check("R5 wdata", int'(mem_wdata), int'(e_wdata));
            end
            check(req_of(host_addr, big_endian), int'(mem_raddr),
                  int'(ref_map(host_addr, big_endian)));
            check("R7 doe", int'(host_doe), int'(!host_cs_n && !host_rd_n));
            if (!host_cs_n && !host_rd_n)
                check("R7 dout", int'(host_dout), int'(bmem[ref_map(host_addr, big_endian)]));
        end
    end

    task automatic bus_write(input logic [10:0] a, input logic [7:0] d, input bit sel);
        @(negedge clk);
        host_cs_n = !sel; host_addr = a; host_din = d; host_wr_n = 1'b0;
        @(negedge clk);
        host_wr_n = 1'b1;
        @(negedge clk);
        host_cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [10:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        host_cs_n = 1'b0; host_rd_n = 1'b0; host_addr = a;
        @(posedge clk); #2;
        check(req, int'(host_dout), int'(exp));
        @(negedge clk);
        host_cs_n = 1'b1; host_rd_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) bmem[i] = 8'(i) ^ 8'hC3;
        #1;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1 we", int'(mem_we), 0);
        check("R1 doe", int'(host_doe), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: little-endian pass-through
        bus_write(11'h020, 8'h5A, 1'b1);
        check("R2 mem", int'(bmem[11'h020]), 8'h5A);
        bus_write(11'h010, 8'h11, 1'b1);
        bus_write(11'h011, 8'h22, 1'b1);
        check("R2 lo", int'(bmem[11'h010]), 8'h11);
        check("R2 hi", int'(bmem[11'h011]), 8'h22);
        bus_read(11'h010, 8'h11, "R2 read");

        // R3: big-endian swap on listed words
        @(negedge clk) big_endian = 1'b1;
        bus_write(11'h010, 8'hA1, 1'b1);
        bus_write(11'h011, 8'hB2, 1'b1);
        check("R3 lo", int'(bmem[11'h010]), 8'hB2);
        check("R3 hi", int'(bmem[11'h011]), 8'hA1);
        bus_write(11'h07C, 8'hC4, 1'b1);
        bus_write(11'h07D, 8'hD5, 1'b1);
        check("R3 wd", int'(bmem[11'h07D]), 8'hC4);
        bus_write(11'h015, 8'h6E, 1'b1);
        check("R3 mode0", int'(bmem[11'h014]), 8'h6E);
        bus_read(11'h012, bmem[11'h013], "R3 read status");
        bus_read(11'h010, 8'hA1, "R3 read even");

        // R4: unlisted neighbours untouched
        bus_write(11'h016, 8'h33, 1'b1);
        check("R4 mem", int'(bmem[11'h016]), 8'h33);
        bus_write(11'h00F, 8'h44, 1'b1);
        check("R4 mem2", int'(bmem[11'h00F]), 8'h44);
        bus_read(11'h07E, 8'h7E ^ 8'hC3, "R4 read");

        // R6: strobe without chip select
        bus_write(11'h030, 8'h99, 1'b0);
        check("R6 mem", int'(bmem[11'h030]), 8'h30 ^ 8'hC3);
        check("R6 we", int'(mem_we), 0);

        // R8: commit and read of the same byte share a cycle
        @(negedge clk);
        host_cs_n = 1'b0; host_addr = 11'h012; host_din = 8'hE7; host_wr_n = 1'b0;
        @(negedge clk);
        host_wr_n = 1'b1; host_rd_n = 1'b0;
        @(posedge clk); #2;
        check("R8 commit", int'(mem_we), 1);
        check("R8 old", int'(host_dout), 8'h13 ^ 8'hC3);
        @(posedge clk); #2;
        check("R8 new", int'(host_dout), 8'hE7);
        @(negedge clk);
        host_cs_n = 1'b1; host_rd_n = 1'b1;

        // R2 again after switching back
        @(negedge clk) big_endian = 1'b0;
        bus_read(11'h013, 8'hE7, "R2 read back");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule